// File: doc/BRIEF.md
# Packetized UART Receive Word FIFO

This block sits behind a serial receiver and turns its byte stream into 32-bit words that software drains through a single read port. Bytes are gathered into packets. A packet ends on an explicit close strobe, after a programmable number of byte-less cycles, or when it reaches a fixed number of full words. Only one packet is presented at a time. The status word shows how many words of that packet are still unread, whether its final word is short, and how many bytes that final word carries.

Packets that close while another one is being drained are held in hidden staging storage. They appear only when the last word of the presented packet has been read, so the visible word count never rises during a drain. Every word before the final one is a full word. A sticky, write-one-to-clear interrupt register records dropped bytes, empty reads and packet arrival.

Top module: `rx_packet_fifo`

## Requirements
- R1: In normal mode, bytes are packed four to a word. The first byte goes in bits [7:0], then [15:8], [23:16] and [31:24]. When `pack_one` is high, each byte fills its own word in bits [7:0]. Byte lanes that receive no byte read as zero.
- R2: `status` bits [15:0] give the number of unread words in the presented packet. Bit [16] is set when that packet's final word is short. Bits [19:17] give the final word's valid byte count (1 to 4), or 0 when no packet is presented. All other bits are zero. Each word read lowers the count by exactly one, and the count never rises while it is nonzero.
- R3: A packet that closes while another is presented stays hidden. It becomes the presented packet in the cycle after the last word of the earlier packet is read.
- R4: Every word of a packet except the final one carries four bytes, whatever the final word's byte count is.
- R5: A high `in_close` ends the open packet. A byte offered in the same cycle as the strobe belongs to the packet being closed. A strobe with no open data has no effect.
- R6: When `idle_limit` is nonzero, an open packet closes after `idle_limit` consecutive cycles with no accepted byte. A value of zero disables this timeout.
- R7: A packet closes by itself once it holds MAX_PKT_WORDS full words. The next byte starts a new packet.
- R8: A byte that needs a fresh word while DEPTH words are already stored is dropped, and it sets interrupt bit 0 (overflow).
- R9: A read while the visible count is zero returns 0 on `rd_data`, leaves the FIFO unchanged and sets interrupt bit 1 (underflow).
- R10: Interrupt bit 2 is set when a packet becomes presented. Writing a one through `irq_clr` under `irq_clr_en` clears the matching bit. A bit that is set and cleared in the same cycle stays set. `irq` is the OR of all three bits.
- R11: After a synchronous reset, `status`, `irq_status`, `irq` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A received byte is offered this cycle |
| in_byte | input | 8 | Received byte |
| in_close | input | 1 | Ends the open packet |
| pack_one | input | 1 | One byte per word when high |
| idle_limit | input | IDLE_W | Idle cycles before auto-close; 0 disables |
| rd_en | input | 1 | Pops the word shown on rd_data |
| rd_data | output | 32 | Head word of the presented packet, 0 when none |
| status | output | 32 | Count, short-word flag, final byte count |
| irq_clr_en | input | 1 | Applies irq_clr this cycle |
| irq_clr | input | 3 | Write-one-to-clear mask |
| irq_status | output | 3 | Sticky bits: overflow, underflow, packet arrival |
| irq | output | 1 | OR of irq_status |

## Verification
Two collisions matter here. The first is an interrupt event landing in the same cycle that software writes its clear. The bench provokes it by issuing an empty read together with a clear of the underflow bit, then requires the bit to read back as one. The second is the read of a packet's last word coinciding with the load of the next hidden packet. The bench provokes it by closing a second packet mid-drain, then requires the new packet's count and byte fields in the very cycle after that final read. Random packet lengths, with random gaps between bytes, also exercise word completion coinciding with a close.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;

    localparam int LANES   = 4;
    localparam int CNT_W   = 16;
    localparam int IRQ_N   = 3;
    localparam int IRQ_OVF = 0;
    localparam int IRQ_UDF = 1;
    localparam int IRQ_PKT = 2;

    // Descriptor of one closed packet
    typedef struct packed {
        logic             partial;
        logic [2:0]       last_bytes;
        logic [CNT_W-1:0] words;
    } pkt_desc_t;

    localparam int DESC_W = $bits(pkt_desc_t);

    function automatic logic [2:0] lanes_per_word(input logic one_byte);
        return one_byte ? 3'd1 : 3'(LANES);
    endfunction

    function automatic logic [31:0] status_word(input pkt_desc_t d);
        return {12'd0, d.last_bytes, d.partial, d.words};
    endfunction

endpackage

// File: rtl/rxpk_sync_fifo.sv
module rxpk_sync_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [CW-1:0]    cnt;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push) wp <= step(wp);
            if (pop)  rp <= step(rp);
            case ({push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign head  = mem[rp];
    assign full  = (cnt == CW'(DEPTH));
    assign empty = (cnt == '0);

    // R8: writes only land in free space
    p_no_push_full_r8: assert property (@(posedge clk) disable iff (rst)
        push |-> !full);
    // R3: reads only take stored entries
    p_no_pop_empty_r3: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

endmodule

// File: rtl/rxpk_assembler.sv
module rxpk_assembler
    import rxpk_pkg::*;
#(
    parameter int MAX_PKT_WORDS = 8,
    parameter int IDLE_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_close,
    input  logic              pack_one,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              space_ok,
    output logic              word_push,
    output logic [31:0]       word_data,
    output logic              desc_push,
    output pkt_desc_t         desc,
    output logic              drop
);
    logic [31:0]       acc, acc_n;
    logic [2:0]        nb, nb_n, bpw;
    logic [CNT_W-1:0]  pw, pw_n;
    logic [IDLE_W-1:0] idle;
    logic take, full_w, open_q, open_n, limit_hit, idle_hit, close, partial;

    always_comb begin
        bpw    = lanes_per_word(pack_one);
        take   = in_valid && ((nb != 3'd0) || space_ok);
        drop   = in_valid && !take;
        acc_n  = acc;
        if (take) acc_n[8*nb[1:0] +: 8] = in_byte;
        nb_n   = nb + {2'b00, take};
        full_w = take && (nb_n == bpw);
        pw_n   = pw + {{(CNT_W-1){1'b0}}, full_w};
        open_q = (pw != '0) || (nb != 3'd0);
        open_n = (pw_n != '0) || (!full_w && (nb_n != 3'd0));
        limit_hit = full_w && (pw_n == CNT_W'(MAX_PKT_WORDS));
        idle_hit  = (idle_limit != '0) && !take && open_q &&
                    ((idle + 1'b1) == idle_limit);
        close     = open_n && (in_close || limit_hit || idle_hit);
        partial   = close && !full_w && (nb_n != 3'd0);

        word_push = full_w || partial;
        word_data = acc_n;
        desc_push = close;
        desc.words      = pw_n + {{(CNT_W-1){1'b0}}, partial};
        desc.last_bytes = partial ? nb_n : bpw;
        desc.partial    = partial;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            nb   <= '0;
            pw   <= '0;
            idle <= '0;
        end else if (close) begin
            acc  <= '0;
            nb   <= '0;
            pw   <= '0;
            idle <= '0;
        end else begin
            acc  <= full_w ? '0 : acc_n;
            nb   <= full_w ? 3'd0 : nb_n;
            pw   <= pw_n;
            idle <= (take || !open_q || (idle_limit == '0)) ? '0 : idle + 1'b1;
        end
    end

    // R1: the pending word never holds a full complement of lanes
    p_lane_bound_r1: assert property (@(posedge clk) disable iff (rst)
        nb < 3'(LANES));
    // R7: an open packet never holds more full words than the limit
    p_word_limit_r7: assert property (@(posedge clk) disable iff (rst)
        pw < CNT_W'(MAX_PKT_WORDS));

endmodule

// File: rtl/rxpk_irq.sv
module rxpk_irq
    import rxpk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [IRQ_N-1:0] set,
    input  logic             clr_en,
    input  logic [IRQ_N-1:0] clr,
    output logic [IRQ_N-1:0] bits
);
    for (genvar i = 0; i < IRQ_N; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                bits[i] <= 1'b0;
            else if (set[i])
                bits[i] <= 1'b1;
            else if (clr_en && clr[i])
                bits[i] <= 1'b0;
        end

        // R10: an event always leaves its bit set
        p_set_wins_r10: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> bits[i]);
    end

endmodule

// File: rtl/rx_packet_fifo.sv
module rx_packet_fifo
    import rxpk_pkg::*;
#(
    parameter int DEPTH         = 16,
    parameter int MAX_PKT_WORDS = 8,
    parameter int IDLE_W        = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_close,
    input  logic              pack_one,
    input  logic [IDLE_W-1:0] idle_limit,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic [31:0]       status,
    input  logic              irq_clr_en,
    input  logic [2:0]        irq_clr,
    output logic [2:0]        irq_status,
    output logic              irq
);
    logic            word_push, desc_push, drop;
    logic [31:0]     word_data, data_head;
    logic            data_full, data_empty, desc_full, desc_empty;
    pkt_desc_t       desc_in, desc_head, vis;
    logic [DESC_W-1:0] desc_head_raw;
    logic            pop, load, underflow;
    logic [IRQ_N-1:0] irq_set;

    rxpk_assembler #(.MAX_PKT_WORDS(MAX_PKT_WORDS), .IDLE_W(IDLE_W)) u_asm (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_byte(in_byte), .in_close(in_close),
        .pack_one(pack_one), .idle_limit(idle_limit),
        .space_ok(!data_full),
        .word_push(word_push), .word_data(word_data),
        .desc_push(desc_push), .desc(desc_in), .drop(drop)
    );

    rxpk_sync_fifo #(.WIDTH(32), .DEPTH(DEPTH)) u_data (
        .clk(clk), .rst(rst),
        .push(word_push), .wdata(word_data), .pop(pop),
        .head(data_head), .full(data_full), .empty(data_empty)
    );

    rxpk_sync_fifo #(.WIDTH(DESC_W), .DEPTH(DEPTH)) u_desc (
        .clk(clk), .rst(rst),
        .push(desc_push), .wdata(desc_in), .pop(load),
        .head(desc_head_raw), .full(desc_full), .empty(desc_empty)
    );

    assign desc_head = pkt_desc_t'(desc_head_raw);

    always_comb begin
        pop       = rd_en && (vis.words != '0);
        underflow = rd_en && (vis.words == '0);
        load      = !desc_empty &&
                    ((vis.words == '0) || (pop && (vis.words == CNT_W'(1))));
        irq_set          = '0;
        irq_set[IRQ_OVF] = drop;
        irq_set[IRQ_UDF] = underflow;
        irq_set[IRQ_PKT] = load;
    end

    always_ff @(posedge clk) begin
        if (rst)
            vis <= '0;
        else if (load)
            vis <= desc_head;
        else if (pop) begin
            if (vis.words == CNT_W'(1))
                vis <= '0;
            else
                vis.words <= vis.words - 1'b1;
        end
    end

    rxpk_irq u_irq (
        .clk(clk), .rst(rst),
        .set(irq_set), .clr_en(irq_clr_en), .clr(irq_clr),
        .bits(irq_status)
    );

    assign rd_data = (vis.words != '0) ? data_head : 32'd0;
    assign status  = status_word(vis);
    assign irq     = |irq_status;

    // R2: outside a reload, the count moves down by exactly the reads taken
    p_count_no_grow_r2: assert property (@(posedge clk) disable iff (rst)
        (vis.words != '0) && !(pop && (vis.words == CNT_W'(1))) |=>
        vis.words == $past(vis.words) - CNT_W'($past(pop)));
    // R2: a presented packet always reports a final byte count of 1..4
    p_last_bytes_r2: assert property (@(posedge clk) disable iff (rst)
        (vis.words != '0) |-> (vis.last_bytes != 3'd0) && (vis.last_bytes <= 3'd4));
    // R9: an empty read raises the underflow bit
    p_underflow_flag_r9: assert property (@(posedge clk) disable iff (rst)
        underflow |=> irq_status[IRQ_UDF]);
    // R8: a dropped byte raises the overflow bit
    p_overflow_flag_r8: assert property (@(posedge clk) disable iff (rst)
        drop |=> irq_status[IRQ_OVF]);
    // R3: descriptors never outrun their storage
    p_desc_room_r3: assert property (@(posedge clk) disable iff (rst)
        desc_push |-> !desc_full);
    // R3: a presented packet always has its words stored
    p_vis_backed_r3: assert property (@(posedge clk) disable iff (rst)
        (vis.words != '0) |-> !data_empty);

endmodule

// File: tb/tb_rx_packet_fifo.sv
`timescale 1ns/1ps
module tb_rx_packet_fifo;
    localparam int DEPTH = 16;
    localparam int MAXW  = 8;
    localparam int IW    = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid, in_close, pack_one, rd_en, irq_clr_en, irq;
    logic [7:0]    in_byte;
    logic [IW-1:0] idle_limit;
    logic [31:0]   rd_data, status;
    logic [2:0]    irq_clr, irq_status;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];

    always #2 clk = ~clk;

    rx_packet_fifo #(.DEPTH(DEPTH), .MAX_PKT_WORDS(MAXW), .IDLE_W(IW)) dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
        .in_close(in_close), .pack_one(pack_one), .idle_limit(idle_limit),
        .rd_en(rd_en), .rd_data(rd_data), .status(status),
        .irq_clr_en(irq_clr_en), .irq_clr(irq_clr),
        .irq_status(irq_status), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [31:0] exp_status(input int words, input int lastb,
                                               input bit part);
        return {12'd0, 3'(lastb), part, 16'(words)};
    endfunction

    task automatic send_byte(input logic [7:0] b);
        in_valid = 1'b1;
        in_byte  = b;
        tick();
        in_valid = 1'b0;
    endtask

    task automatic close_pkt();
        in_close = 1'b1;
        tick();
        in_close = 1'b0;
    endtask

    task automatic read_word(output logic [31:0] d);
        d     = rd_data;
        rd_en = 1'b1;
        tick();
        rd_en = 1'b0;
    endtask

    task automatic clear_irq(input logic [2:0] m);
        irq_clr_en = 1'b1;
        irq_clr    = m;
        tick();
        irq_clr_en = 1'b0;
        irq_clr    = '0;
    endtask

    task automatic wait_visible();
        for (int i = 0; i < 40; i++) begin
            if (status[15:0] != 16'd0) break;
            tick();
        end
    endtask

    // Queue a packet of L random bytes into the model and the DUT
    task automatic send_pkt(input int L, input bit gaps);
        for (int i = 0; i < L; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_q.push_back(b);
            send_byte(b);
            if (gaps && ($urandom % 4 == 0)) tick();
        end
        close_pkt();
    endtask

    // Drain a packet of L bytes (four per word) and compare everything
    task automatic drain_pkt(input int L, input string tag);
        int nw, r;
        logic [31:0] d, e;
        nw = (L + 3) / 4;
        r  = L % 4;
        wait_visible();
        chk(status == exp_status(nw, (r != 0) ? r : 4, r != 0),
            {tag, " R2 R4 status"}, status, exp_status(nw, (r != 0) ? r : 4, r != 0));
        for (int w = 0; w < nw; w++) begin
            e = '0;
            for (int k = 0; k < 4; k++)
                if (w * 4 + k < L) e[8*k +: 8] = exp_q.pop_front();
            read_word(d);
            chk(d == e, {tag, " R1 R4 data"}, d, e);
            if (w < nw - 1)
                chk(status[15:0] == 16'(nw - 1 - w), {tag, " R2 decrement"},
                    {16'd0, status[15:0]}, 32'(nw - 1 - w));
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] d;
        int lens[$];
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; in_valid = 0; in_close = 0; pack_one = 0; rd_en = 0;
        irq_clr_en = 0; irq_clr = '0; in_byte = '0; idle_limit = '0;
        repeat (3) tick();
        // R11 reset state
        chk(status == 32'd0, "R11 status", status, 0);
        chk(irq_status == 3'd0 && irq == 1'b0, "R11 irq", {28'd0, irq, irq_status}, 0);
        chk(rd_data == 32'd0, "R11 rd_data", rd_data, 0);
        rst = 1'b0;
        tick();

        // R9 empty read
        read_word(d);
        chk(d == 32'd0, "R9 empty data", d, 0);
        chk(status == 32'd0, "R9 no state change", status, 0);
        chk(irq_status[1] == 1'b1, "R9 underflow bit", {29'd0, irq_status}, 3'b010);
        clear_irq(3'b111);

        // R10 set and clear in the same cycle: set wins
        rd_en = 1'b1; irq_clr_en = 1'b1; irq_clr = 3'b010;
        tick();
        rd_en = 1'b0; irq_clr_en = 1'b0; irq_clr = '0;
        chk(irq_status[1] == 1'b1, "R10 set wins", {29'd0, irq_status}, 3'b010);
        clear_irq(3'b010);
        chk(irq_status == 3'd0 && !irq, "R10 clear", {29'd0, irq_status}, 0);

        // R5 close with nothing open
        close_pkt();
        repeat (5) tick();
        chk(status == 32'd0, "R5 empty close", status, 0);
        chk(irq_status[2] == 1'b0, "R5 no packet event", {29'd0, irq_status}, 0);

        // R5 byte and close in the same cycle
        in_valid = 1'b1; in_byte = 8'hA5; in_close = 1'b1;
        tick();
        in_valid = 1'b0; in_close = 1'b0;
        wait_visible();
        chk(status == exp_status(1, 1, 1'b1), "R5 same-cycle close", status,
            exp_status(1, 1, 1'b1));
        chk(irq_status[2] && irq, "R10 packet event", {28'd0, irq, irq_status}, 32'b1100);
        read_word(d);
        chk(d == 32'h0000_00A5, "R5 R1 data", d, 32'h0000_00A5);
        clear_irq(3'b100);
        chk(irq_status == 3'd0, "R10 clear packet bit", {29'd0, irq_status}, 0);

        // R3 hidden packet while draining, plus R2 decrement and R4 ordering
        send_pkt(10, 1'b0);
        wait_visible();
        chk(status == exp_status(3, 2, 1'b1), "R4 status 10B", status, exp_status(3, 2, 1'b1));
        read_word(d);
        chk(d == {exp_q[3], exp_q[2], exp_q[1], exp_q[0]}, "R4 first word full", d,
            {exp_q[3], exp_q[2], exp_q[1], exp_q[0]});
        for (int i = 0; i < 4; i++) void'(exp_q.pop_front());
        chk(status[15:0] == 16'd2, "R2 count after read", status, 2);
        send_pkt(5, 1'b0);
        repeat (3) tick();
        chk(status == exp_status(2, 2, 1'b1), "R3 hidden packet", status, exp_status(2, 2, 1'b1));
        read_word(d);
        chk(d == {exp_q[3], exp_q[2], exp_q[1], exp_q[0]}, "R4 middle word", d,
            {exp_q[3], exp_q[2], exp_q[1], exp_q[0]});
        for (int i = 0; i < 4; i++) void'(exp_q.pop_front());
        read_word(d);
        chk(d == {16'd0, exp_q[1], exp_q[0]}, "R4 final partial", d, {16'd0, exp_q[1], exp_q[0]});
        void'(exp_q.pop_front()); void'(exp_q.pop_front());
        chk(status == exp_status(2, 1, 1'b1), "R3 next packet visible", status,
            exp_status(2, 1, 1'b1));
        drain_pkt(5, "R3 second");

        // R1 one byte per word
        pack_one = 1'b1;
        send_byte(8'h11); send_byte(8'h22); send_byte(8'h33);
        close_pkt();
        wait_visible();
        chk(status == exp_status(3, 1, 1'b0), "R1 one-byte status", status, exp_status(3, 1, 1'b0));
        read_word(d); chk(d == 32'h11, "R1 one-byte w0", d, 32'h11);
        read_word(d); chk(d == 32'h22, "R1 one-byte w1", d, 32'h22);
        read_word(d); chk(d == 32'h33, "R1 one-byte w2", d, 32'h33);
        pack_one = 1'b0;

        // R6 idle close
        idle_limit = 16'd10;
        for (int i = 0; i < 6; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_q.push_back(b);
            send_byte(b);
        end
        repeat (5) tick();
        chk(status == 32'd0, "R6 not yet closed", status, 0);
        drain_pkt(6, "R6 idle");
        idle_limit = '0;

        // R7 word limit
        for (int i = 0; i < 36; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_q.push_back(b);
            send_byte(b);
        end
        close_pkt();
        drain_pkt(32, "R7 limit");
        drain_pkt(4, "R7 tail");

        // R8 overflow
        clear_irq(3'b111);
        for (int i = 0; i < 64; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            exp_q.push_back(b);
            send_byte(b);
        end
        chk(irq_status[0] == 1'b0, "R8 no early overflow", {29'd0, irq_status}, 0);
        send_byte(8'hEE);
        chk(irq_status[0] == 1'b1, "R8 overflow bit", {29'd0, irq_status}, 1);
        close_pkt();
        drain_pkt(32, "R8 first");
        drain_pkt(32, "R8 second");
        repeat (3) tick();
        chk(status == 32'd0, "R8 dropped byte absent", status, 0);
        clear_irq(3'b111);

        // Random packets with random gaps
        for (int round = 0; round < 40; round++) begin
            int total;
            total = 0;
            lens.delete();
            for (int p = 0; p < 3; p++) begin
                int L;
                L = 1 + int'($urandom % (MAXW * 4));
                if (total + (L + 3) / 4 > DEPTH) break;
                total += (L + 3) / 4;
                lens.push_back(L);
                send_pkt(L, 1'b1);
            end
            foreach (lens[i]) drain_pkt(lens[i], "R1 R2 R4 random");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule